// File: doc/BRIEF.md
# Switch Address and ID Route Decoder

This block sits behind one ingress port of a packet switch and decides, for each address-routed or ID-routed request header presented to it, where the packet goes. There are four outcomes. The switch may consume it. It may forward it to exactly one downstream port. It may forward it to the upstream port. It may reject it as an Unsupported Request (UR). The decision has two steps. First the header is compared against the switch's own two address windows (BARs) or its own requester ID. Only when that fails are the per-port bridge windows consulted.

Each downstream port has a non-prefetchable memory window, a prefetchable memory window, an IO window and a secondary-to-subordinate bus range. When no window matches, the outcome depends on the side the packet entered from. A packet from the upstream (primary) side becomes UR. A packet from a downstream (secondary) port is sent upstream. A type-0 configuration write seen on the primary side is consumed, and it also teaches the switch its own bus and device number. The decision is registered and appears one clock after the header.

Top module: `sw_route_dec`

## Requirements
- R1: A header presented with `hdr_valid` high yields `out_valid` high on the next clock with exactly one of `out_dn` (one bit), `out_up`, `out_local`, `out_ur` set. With no header, all result outputs are low on the next clock and during reset. Kind encoding: 0 memory, 1 IO, 2 ID-routed, 3 type-0 configuration write.
- R2: A memory or IO request whose address lies in either BAR window (lo <= addr <= hi) is consumed locally, even when a downstream window also covers the address.
- R3: A memory request that misses the BARs goes to the downstream port whose non-prefetchable or prefetchable window contains the address.
- R4: IO requests are matched only against IO windows, and memory requests only against the two memory windows.
- R5: Any window or BAR whose upper bound is below its lower bound matches nothing.
- R6: When several downstream ports match, the lowest-numbered one is chosen.
- R7: A request from the primary side that matches nothing becomes UR.
- R8: A request from a downstream port that matches nothing is sent upstream. The ingress port's own windows and bus range are skipped, so a packet is never sent back out of the port it came in on.
- R9: An ID-routed request whose target ID (bus in bits 15:8, device in 7:3, function in 2:0) equals the captured bus and device, with a function number below `NUM_FN`, is consumed. Otherwise it goes to the port with secondary <= bus <= subordinate.
- R10: A type-0 configuration write from the primary side is consumed and latches the target ID's bus and device as the switch's own ID. After reset the own ID is bus 0, device 0. The same write from a downstream port changes nothing and is sent upstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_kind | input | 2 | Request kind (0 mem, 1 IO, 2 ID, 3 cfg0 write) |
| hdr_addr | input | ADDR_W | Request address |
| hdr_rid | input | 16 | Target ID {bus, device, function} |
| in_from_dn | input | 1 | 1 = entered from a downstream port |
| in_port | input | PIDX_W | Downstream ingress port index |
| bar_lo | input | 2 x ADDR_W | Lower bounds of the two own windows |
| bar_hi | input | 2 x ADDR_W | Upper bounds of the two own windows |
| dn_mem_lo | input | NPORT x ADDR_W | Non-prefetchable window lower bounds |
| dn_mem_hi | input | NPORT x ADDR_W | Non-prefetchable window upper bounds |
| dn_pf_lo | input | NPORT x ADDR_W | Prefetchable window lower bounds |
| dn_pf_hi | input | NPORT x ADDR_W | Prefetchable window upper bounds |
| dn_io_lo | input | NPORT x ADDR_W | IO window lower bounds |
| dn_io_hi | input | NPORT x ADDR_W | IO window upper bounds |
| dn_sec_bus | input | NPORT x 8 | Secondary bus numbers |
| dn_sub_bus | input | NPORT x 8 | Subordinate bus numbers |
| out_valid | output | 1 | Result valid |
| out_dn | output | NPORT | One-hot downstream destination |
| out_up | output | 1 | Forward upstream |
| out_local | output | 1 | Consume internally |
| out_ur | output | 1 | Unsupported Request |

## Verification
On every cycle, the checker confirms that each result carries exactly one destination and that the result tracks the header one clock later. It also confirms that UR only follows primary-side packets, that upstream forwarding only follows downstream-side packets, that no packet is reflected to its ingress port, and that primary type-0 writes are consumed. Which port wins, whether a disabled window stays silent, and whether BAR priority, the memory/IO window split and ID capture and reset hold can only be shown by the bench. It does so with a fixed window map whose windows overlap, are disabled, or touch at their bounds.

// File: rtl/sw_route_pkg.sv
package sw_route_pkg;

   localparam int BUS_W = 8;
   localparam int DEV_W = 5;
   localparam int FN_W  = 3;
   localparam int RID_W = BUS_W + DEV_W + FN_W;

   typedef enum logic [1:0] {
      KIND_MEM  = 2'd0,
      KIND_IO   = 2'd1,
      KIND_ID   = 2'd2,
      KIND_CFG0 = 2'd3
   } route_kind_e;

   typedef struct packed {
      logic [BUS_W-1:0] bus;
      logic [DEV_W-1:0] dev;
      logic [FN_W-1:0]  fn;
   } rid_t;

endpackage

// File: rtl/sw_win_cmp.sv
// Inclusive range compare; an inverted range (hi < lo) never hits.
module sw_win_cmp #(
   parameter int W = 64
) (
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   input  logic [W-1:0] val,
   output logic         hit
);
   logic enabled;
   assign enabled = (hi >= lo);
   assign hit     = enabled && (val >= lo) && (val <= hi);
endmodule

// File: rtl/sw_port_match.sv
// Per-port decode: selects which window applies for the request kind.
module sw_port_match
   import sw_route_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  route_kind_e       kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  bus,
   input  logic [ADDR_W-1:0] mem_lo,
   input  logic [ADDR_W-1:0] mem_hi,
   input  logic [ADDR_W-1:0] pf_lo,
   input  logic [ADDR_W-1:0] pf_hi,
   input  logic [ADDR_W-1:0] io_lo,
   input  logic [ADDR_W-1:0] io_hi,
   input  logic [BUS_W-1:0]  sec_bus,
   input  logic [BUS_W-1:0]  sub_bus,
   output logic              hit
);
   logic mem_h, pf_h, io_h, bus_h;

   sw_win_cmp #(.W(ADDR_W)) u_mem (.lo(mem_lo),  .hi(mem_hi),  .val(addr), .hit(mem_h));
   sw_win_cmp #(.W(ADDR_W)) u_pf  (.lo(pf_lo),   .hi(pf_hi),   .val(addr), .hit(pf_h));
   sw_win_cmp #(.W(ADDR_W)) u_io  (.lo(io_lo),   .hi(io_hi),   .val(addr), .hit(io_h));
   sw_win_cmp #(.W(BUS_W))  u_bus (.lo(sec_bus), .hi(sub_bus), .val(bus),  .hit(bus_h));

   always_comb begin
      unique case (kind)
         KIND_MEM: hit = mem_h | pf_h;
         KIND_IO:  hit = io_h;
         KIND_ID:  hit = bus_h;
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/sw_prio_pick.sv
// Lowest-index-wins one-hot selector.
module sw_prio_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N];
endmodule

// File: rtl/sw_id_capture.sv
// Holds the switch's own bus/device number; cleared by reset.
module sw_id_capture
   import sw_route_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [BUS_W-1:0] cap_bus,
   input  logic [DEV_W-1:0] cap_dev,
   output logic [BUS_W-1:0] own_bus,
   output logic [DEV_W-1:0] own_dev
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_bus <= '0;
         own_dev <= '0;
      end else if (cap_en) begin
         own_bus <= cap_bus;
         own_dev <= cap_dev;
      end
   end
endmodule

// File: rtl/sw_route_dec.sv
module sw_route_dec
   import sw_route_pkg::*;
#(
   parameter int NPORT  = 4,
   parameter int ADDR_W = 64,
   parameter int NUM_FN = 1,
   localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         hdr_valid,
   input  logic [1:0]                   hdr_kind,
   input  logic [ADDR_W-1:0]            hdr_addr,
   input  logic [RID_W-1:0]             hdr_rid,
   input  logic                         in_from_dn,
   input  logic [PIDX_W-1:0]            in_port,
   input  logic [1:0][ADDR_W-1:0]       bar_lo,
   input  logic [1:0][ADDR_W-1:0]       bar_hi,
   input  logic [NPORT-1:0][ADDR_W-1:0] dn_mem_lo,
   input  logic [NPORT-1:0][ADDR_W-1:0] dn_mem_hi,
   input  logic [NPORT-1:0][ADDR_W-1:0] dn_pf_lo,
   input  logic [NPORT-1:0][ADDR_W-1:0] dn_pf_hi,
   input  logic [NPORT-1:0][ADDR_W-1:0] dn_io_lo,
   input  logic [NPORT-1:0][ADDR_W-1:0] dn_io_hi,
   input  logic [NPORT-1:0][BUS_W-1:0]  dn_sec_bus,
   input  logic [NPORT-1:0][BUS_W-1:0]  dn_sub_bus,
   output logic                         out_valid,
   output logic [NPORT-1:0]             out_dn,
   output logic                         out_up,
   output logic                         out_local,
   output logic                         out_ur
);

   localparam logic [FN_W:0] FN_CNT = (FN_W+1)'(NUM_FN);
   localparam int NBAR = 2;

   if (NPORT < 1 || NPORT > 8) begin : g_bad_nport
      $error("sw_route_dec: NPORT must be 1..8");
   end
   if (NUM_FN < 1 || NUM_FN > 8) begin : g_bad_numfn
      $error("sw_route_dec: NUM_FN must be 1..8");
   end
   if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addrw
      $error("sw_route_dec: ADDR_W must be 32..64");
   end

   route_kind_e kind;
   rid_t        rid;
   assign kind = route_kind_e'(hdr_kind);
   assign rid  = rid_t'(hdr_rid);

   // ---------------- stage 1: internal target ----------------
   logic [NBAR-1:0] bar_h;
   for (genvar b = 0; b < NBAR; b++) begin : g_bar
      sw_win_cmp #(.W(ADDR_W)) u_bar (
         .lo (bar_lo[b]),
         .hi (bar_hi[b]),
         .val(hdr_addr),
         .hit(bar_h[b])
      );
   end

   logic [BUS_W-1:0] own_bus;
   logic [DEV_W-1:0] own_dev;
   logic             cap_en;

   assign cap_en = hdr_valid && (kind == KIND_CFG0) && !in_from_dn;

   sw_id_capture u_idcap (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .cap_bus(rid.bus),
      .cap_dev(rid.dev),
      .own_bus(own_bus),
      .own_dev(own_dev)
   );

   logic addr_kind, bar_local, id_local, cfg_local, is_local;
   assign addr_kind = (kind == KIND_MEM) || (kind == KIND_IO);
   assign bar_local = addr_kind && (|bar_h);
   assign id_local  = (kind == KIND_ID) && (rid.bus == own_bus) &&
                      (rid.dev == own_dev) && ({1'b0, rid.fn} < FN_CNT);
   assign cfg_local = (kind == KIND_CFG0) && !in_from_dn;
   assign is_local  = bar_local || id_local || cfg_local;

   // ---------------- stage 2: bridge windows ----------------
   logic [NPORT-1:0] port_h, excl, cand, grant;
   logic             any_port;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      sw_port_match #(.ADDR_W(ADDR_W)) u_match (
         .kind   (kind),
         .addr   (hdr_addr),
         .bus    (rid.bus),
         .mem_lo (dn_mem_lo[p]),
         .mem_hi (dn_mem_hi[p]),
         .pf_lo  (dn_pf_lo[p]),
         .pf_hi  (dn_pf_hi[p]),
         .io_lo  (dn_io_lo[p]),
         .io_hi  (dn_io_hi[p]),
         .sec_bus(dn_sec_bus[p]),
         .sub_bus(dn_sub_bus[p]),
         .hit    (port_h[p])
      );
      assign excl[p] = in_from_dn && (in_port == PIDX_W'(p));
   end

   assign cand = port_h & ~excl;

   sw_prio_pick #(.N(NPORT)) u_pick (
      .req  (cand),
      .grant(grant),
      .any  (any_port)
   );

   // ---------------- final choice ----------------
   logic [NPORT-1:0] nxt_dn;
   logic             nxt_up, nxt_local, nxt_ur;

   always_comb begin
      nxt_dn    = '0;
      nxt_up    = 1'b0;
      nxt_local = 1'b0;
      nxt_ur    = 1'b0;
      if (hdr_valid) begin
         if (is_local)        nxt_local = 1'b1;
         else if (any_port)   nxt_dn    = grant;
         else if (in_from_dn) nxt_up    = 1'b1;
         else                 nxt_ur    = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_dn    <= '0;
         out_up    <= 1'b0;
         out_local <= 1'b0;
         out_ur    <= 1'b0;
      end else begin
         out_valid <= hdr_valid;
         out_dn    <= nxt_dn;
         out_up    <= nxt_up;
         out_local <= nxt_local;
         out_ur    <= nxt_ur;
      end
   end

endmodule

// File: rtl/sw_route_dec_chk.sv
module sw_route_dec_chk #(
   parameter int NPORT  = 4,
   parameter int PIDX_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hdr_valid,
   input logic [1:0]        hdr_kind,
   input logic              in_from_dn,
   input logic [PIDX_W-1:0] in_port,
   input logic              out_valid,
   input logic [NPORT-1:0]  out_dn,
   input logic              out_up,
   input logic              out_local,
   input logic              out_ur
);
   logic              prv_from_dn;
   logic [PIDX_W-1:0] prv_port;
   logic [1:0]        prv_kind;
   logic [NPORT-1:0]  prv_ing_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_from_dn <= 1'b0;
         prv_port    <= '0;
         prv_kind    <= '0;
      end else begin
         prv_from_dn <= in_from_dn;
         prv_port    <= in_port;
         prv_kind    <= hdr_kind;
      end
   end

   always_comb begin
      for (int i = 0; i < NPORT; i++)
         prv_ing_mask[i] = prv_from_dn && (prv_port == PIDX_W'(i));
   end

   // R1: a result follows every header one clock later
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> out_valid);
   p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> !out_valid);
   // R1: exactly one destination per result
   p_one_dest_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones({out_dn, out_up, out_local, out_ur}) == 1));
   // R1: silent when nothing is valid
   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ({out_dn, out_up, out_local, out_ur} == '0));
   // R7: UR only for primary-side ingress
   p_ur_primary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ur) |-> !prv_from_dn);
   // R8: upstream only for downstream-side ingress
   p_up_secondary_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_up) |-> prv_from_dn);
   // R8: never reflected to the ingress port
   p_no_reflect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_dn & prv_ing_mask) == '0));
   // R10: primary type-0 config write is consumed
   p_cfg_local_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && prv_kind == 2'd3 && !prv_from_dn) |-> out_local);
endmodule

bind sw_route_dec sw_route_dec_chk #(.NPORT(NPORT), .PIDX_W(PIDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hdr_valid (hdr_valid),
   .hdr_kind  (hdr_kind),
   .in_from_dn(in_from_dn),
   .in_port   (in_port),
   .out_valid (out_valid),
   .out_dn    (out_dn),
   .out_up    (out_up),
   .out_local (out_local),
   .out_ur    (out_ur)
);

// File: tb/sw_route_dec_bench.sv
`timescale 1ns/1ps
module sw_route_dec_bench;

   localparam int NP = 4;
   localparam int AW = 64;

   // expected code: 0..3 downstream port, 4 up, 5 local, 6 UR
   typedef struct packed {
      logic [1:0]  kind;
      logic        sec;
      logic [1:0]  port;
      logic [63:0] addr;
      logic [15:0] rid;
      logic [2:0]  exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 38;
   localparam vec_t VECS [NV] = '{
      '{2'd0,1'b0,2'd0,64'h0000_0000_8000_1000,16'h0000,3'd5,4'd2},  // R2 BAR beats port0 mem
      '{2'd0,1'b0,2'd0,64'h0000_0000_8000_FFFF,16'h0000,3'd5,4'd2},  // R2 BAR upper bound
      '{2'd0,1'b0,2'd0,64'h0000_0000_8001_0000,16'h0000,3'd0,4'd3},  // R3 port0 mem
      '{2'd0,1'b0,2'd0,64'h0000_0000_8900_0000,16'h0000,3'd0,4'd6},  // R6 overlap port0/1
      '{2'd0,1'b0,2'd0,64'h0000_0000_9000_0000,16'h0000,3'd1,4'd3},  // R3 port1 mem
      '{2'd0,1'b0,2'd0,64'h0000_0001_2345_0000,16'h0000,3'd0,4'd3},  // R3 port0 prefetchable
      '{2'd0,1'b0,2'd0,64'h0000_0002_0000_0000,16'h0000,3'd2,4'd3},  // R3 port2 prefetchable
      '{2'd0,1'b0,2'd0,64'h0000_0002_1000_0000,16'h0000,3'd6,4'd7},  // R7 miss
      '{2'd0,1'b0,2'd0,64'h0000_0000_7FFF_FFFF,16'h0000,3'd6,4'd7},  // R7 just below windows
      '{2'd0,1'b0,2'd0,64'h0000_0000_0000_1800,16'h0000,3'd6,4'd5},  // R5 BAR1 disabled, R4 IO window ignored
      '{2'd1,1'b0,2'd0,64'h0000_0000_0000_1800,16'h0000,3'd0,4'd4},  // R4 IO port0
      '{2'd1,1'b0,2'd0,64'h0000_0000_9000_0000,16'h0000,3'd6,4'd4},  // R4 mem windows ignored for IO
      '{2'd1,1'b0,2'd0,64'h0000_0000_0000_3FFF,16'h0000,3'd3,4'd4},  // R4 IO upper bound port3
      '{2'd1,1'b0,2'd0,64'h0000_0000_0000_4000,16'h0000,3'd6,4'd7},  // R7 IO miss
      '{2'd1,1'b0,2'd0,64'h0000_0000_8000_0010,16'h0000,3'd5,4'd2},  // R2 IO to BAR
      '{2'd0,1'b1,2'd1,64'h0000_0000_8900_0000,16'h0000,3'd0,4'd6},  // R6 from port1
      '{2'd0,1'b1,2'd0,64'h0000_0000_8900_0000,16'h0000,3'd1,4'd8},  // R8 skip ingress port0
      '{2'd0,1'b1,2'd0,64'h0000_0000_8001_0000,16'h0000,3'd4,4'd8},  // R8 own window -> up
      '{2'd0,1'b1,2'd2,64'h0000_0000_C000_0000,16'h0000,3'd4,4'd8},  // R8 miss -> up
      '{2'd0,1'b1,2'd3,64'h0000_0000_8000_2000,16'h0000,3'd5,4'd2},  // R2 from downstream
      '{2'd2,1'b0,2'd0,64'h0,16'h0000,3'd5,4'd10},                   // R10 reset ID 0:0
      '{2'd2,1'b0,2'd0,64'h0,16'h0001,3'd6,4'd9},                    // R9 fn 1 not implemented
      '{2'd2,1'b0,2'd0,64'h0,16'h0500,3'd1,4'd9},                    // R9 bus 5 -> port1
      '{2'd2,1'b0,2'd0,64'h0,16'h0A00,3'd3,4'd9},                    // R9 bus 10 lower bound
      '{2'd2,1'b0,2'd0,64'h0,16'h1400,3'd3,4'd9},                    // R9 bus 20 upper bound
      '{2'd2,1'b0,2'd0,64'h0,16'h1500,3'd6,4'd9},                    // R9 bus 21 miss
      '{2'd2,1'b0,2'd0,64'h0,16'h0900,3'd2,4'd9},                    // R9 single-bus range
      '{2'd3,1'b0,2'd0,64'h0,16'h0118,3'd5,4'd10},                   // R10 capture 1:3
      '{2'd2,1'b0,2'd0,64'h0,16'h0118,3'd5,4'd10},                   // R10 new ID consumed
      '{2'd2,1'b0,2'd0,64'h0,16'h0000,3'd6,4'd10},                   // R10 old ID gone
      '{2'd3,1'b1,2'd2,64'h0,16'h0708,3'd4,4'd10},                   // R10 cfg from downstream -> up
      '{2'd2,1'b0,2'd0,64'h0,16'h0118,3'd5,4'd10},                   // R10 ID unchanged
      '{2'd2,1'b0,2'd0,64'h0,16'h0708,3'd1,4'd10},                   // R10 7:1 not captured
      '{2'd2,1'b1,2'd1,64'h0,16'h0600,3'd4,4'd8},                    // R8 ID own range -> up
      '{2'd2,1'b1,2'd3,64'h0,16'h0118,3'd5,4'd9},                    // R9 local from downstream
      '{2'd2,1'b1,2'd0,64'h0,16'h0A00,3'd3,4'd9},                    // R9 downstream to downstream
      '{2'd0,1'b0,2'd0,64'h0000_0000_B000_0000,16'h0000,3'd6,4'd5},  // R5 port2 mem disabled
      '{2'd0,1'b0,2'd0,64'h0000_0003_0000_0000,16'h0000,3'd6,4'd5}   // R5 port1 pf disabled
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic                     hdr_valid = 1'b0;
   logic [1:0]               hdr_kind = '0;
   logic [AW-1:0]            hdr_addr = '0;
   logic [15:0]              hdr_rid = '0;
   logic                     in_from_dn = 1'b0;
   logic [1:0]               in_port = '0;
   logic [1:0][AW-1:0]       bar_lo, bar_hi;
   logic [NP-1:0][AW-1:0]    dn_mem_lo, dn_mem_hi, dn_pf_lo, dn_pf_hi, dn_io_lo, dn_io_hi;
   logic [NP-1:0][7:0]       dn_sec_bus, dn_sub_bus;
   logic                     out_valid, out_up, out_local, out_ur;
   logic [NP-1:0]            out_dn;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   sw_route_dec u_sw_route_dec (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_kind(hdr_kind),
      .hdr_addr(hdr_addr), .hdr_rid(hdr_rid), .in_from_dn(in_from_dn), .in_port(in_port),
      .bar_lo(bar_lo), .bar_hi(bar_hi),
      .dn_mem_lo(dn_mem_lo), .dn_mem_hi(dn_mem_hi), .dn_pf_lo(dn_pf_lo), .dn_pf_hi(dn_pf_hi),
      .dn_io_lo(dn_io_lo), .dn_io_hi(dn_io_hi), .dn_sec_bus(dn_sec_bus), .dn_sub_bus(dn_sub_bus),
      .out_valid(out_valid), .out_dn(out_dn), .out_up(out_up), .out_local(out_local), .out_ur(out_ur)
   );

   function automatic logic [7:0] exp_bits(input logic [2:0] code);
      // {valid, dn[3:0], up, local, ur}
      case (code)
         3'd4:    return 8'b1_0000_100;
         3'd5:    return 8'b1_0000_010;
         3'd6:    return 8'b1_0000_001;
         default: return {1'b1, 4'(1 << code), 3'b000};
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] exp);
      logic [7:0] got;
      got = {out_valid, out_dn, out_up, out_local, out_ur};
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic send(input logic [1:0] k, input logic s, input logic [1:0] p,
                       input logic [63:0] a, input logic [15:0] r);
      @(negedge clk);
      hdr_valid = 1'b1; hdr_kind = k; in_from_dn = s; in_port = p;
      hdr_addr = a; hdr_rid = r;
      @(negedge clk);
      hdr_valid = 1'b0;
   endtask

   initial begin
      bar_lo[0] = 64'h8000_0000; bar_hi[0] = 64'h8000_FFFF;
      bar_lo[1] = 64'h2000;      bar_hi[1] = 64'h1000;           // disabled
      dn_mem_lo[0] = 64'h8000_0000;   dn_mem_hi[0] = 64'h8FFF_FFFF;
      dn_pf_lo[0]  = 64'h1_0000_0000; dn_pf_hi[0]  = 64'h1_FFFF_FFFF;
      dn_io_lo[0]  = 64'h1000;        dn_io_hi[0]  = 64'h1FFF;
      dn_sec_bus[0] = 8'd2;  dn_sub_bus[0] = 8'd4;
      dn_mem_lo[1] = 64'h8800_0000;   dn_mem_hi[1] = 64'h9FFF_FFFF;
      dn_pf_lo[1]  = 64'h3_0000_0000; dn_pf_hi[1]  = 64'h2_FFFF_FFFF; // disabled
      dn_io_lo[1]  = 64'h2000;        dn_io_hi[1]  = 64'h2FFF;
      dn_sec_bus[1] = 8'd5;  dn_sub_bus[1] = 8'd8;
      dn_mem_lo[2] = 64'hB000_0000;   dn_mem_hi[2] = 64'h0;            // disabled
      dn_pf_lo[2]  = 64'h2_0000_0000; dn_pf_hi[2]  = 64'h2_0FFF_FFFF;
      dn_io_lo[2]  = 64'h5000;        dn_io_hi[2]  = 64'h4000;         // disabled
      dn_sec_bus[2] = 8'd9;  dn_sub_bus[2] = 8'd9;
      dn_mem_lo[3] = 64'hA000_0000;   dn_mem_hi[3] = 64'hAFFF_FFFF;
      dn_pf_lo[3]  = 64'h4_0000_0000; dn_pf_hi[3]  = 64'h3_0000_0000; // disabled
      dn_io_lo[3]  = 64'h3000;        dn_io_hi[3]  = 64'h3FFF;
      dn_sec_bus[3] = 8'd10; dn_sub_bus[3] = 8'd20;

      // R1: reset state, even with a header pending
      repeat (3) @(negedge clk);
      hdr_valid = 1'b1;
      @(negedge clk);
      check("R1 reset outputs", 8'h00);
      hdr_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", 8'h00);

      for (int i = 0; i < NV; i++) begin
         send(VECS[i].kind, VECS[i].sec, VECS[i].port, VECS[i].addr, VECS[i].rid);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), exp_bits(VECS[i].exp));
      end

      // R1: output drops when no header follows
      @(negedge clk);
      check("R1 idle gap", 8'h00);

      // R1: back-to-back headers each get their own result
      @(negedge clk);
      hdr_valid = 1'b1; hdr_kind = 2'd0; in_from_dn = 1'b0; hdr_addr = 64'h9000_0000;
      @(negedge clk);
      check("R1 back-to-back first", exp_bits(3'd1));
      hdr_addr = 64'hA000_0000;
      @(negedge clk);
      check("R1 back-to-back second", exp_bits(3'd3));
      hdr_valid = 1'b0;

      // R10: reset returns own ID to 0:0
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      send(2'd2, 1'b0, 2'd0, 64'h0, 16'h0118);
      check("R10 captured ID cleared by reset", exp_bits(3'd6));
      send(2'd2, 1'b0, 2'd0, 64'h0, 16'h0000);
      check("R10 zero ID after reset", exp_bits(3'd5));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog got=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule